// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits in the memory stage of a 32-bit in-order pipeline, between the core and a data memory that is one word wide. It is purely combinational, so an access is set up and completed within one stage.

On a store it takes the byte address, a 3-bit access code and the register value. It then produces a word-aligned memory address, one write strobe per byte lane, and write data with the value copied into every lane it could land in. On a load it takes the word returned by memory and picks out the addressed byte, halfword or word, using little-endian lane order. It then extends the result to 32 bits with either sign or zero fill.

An access whose address does not suit its size raises a flag. That flag blocks all strobes and clears the load result. The core, not this block, decides what to do with the flag. No handshake is needed at the edges: there is no storage, and every output follows its inputs within the same cycle.

Top module: `mem_lane_align`

## Requirements
- R1: `mem_addr_o` equals `addr_i` with its two low bits forced to zero, for every access.
- R2: A store with code 000 (byte) drives strobe bit `addr_i[1:0]` alone and replicates `store_data_i[7:0]` into all four lanes of `wr_data_o`.
- R3: A store with code 001 (halfword) and `addr_i[0]`=0 drives strobe 0011 when `addr_i[1]`=0 and 1100 when `addr_i[1]`=1, and replicates `store_data_i[15:0]` into both halves of `wr_data_o`.
- R4: A store with code 010 (word) at an address with both low bits zero drives strobe 1111 and passes `store_data_i` unchanged.
- R5: `misalign_o` is 1 for code 001 or 101 when `addr_i[0]`=1, and for code 010 when `addr_i[1:0]`≠0. It is 0 for byte codes and for unsupported codes, on both loads and stores.
- R6: While `misalign_o` is 1, the strobes are 0000 and `load_data_o` is zero.
- R7: When `is_store_i` is 0, the strobes are 0000 whatever the code and address.
- R8: A load with code 000 returns byte lane `addr_i[1:0]` of `mem_rdata_i`, sign-extended. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R9: A load with code 100 returns the same byte as R8, zero-extended.
- R10: A load with code 001 returns the halfword at bits 15:0 when `addr_i[1]`=0, or at bits 31:16 when it is 1, sign-extended. Code 101 returns the same halfword zero-extended.
- R11: A load with code 010 at an aligned address returns `mem_rdata_i` unchanged.
- R12: Codes 011, 110 and 111 give strobes 0000, `load_data_o` zero and `misalign_o` 0. A store with code 100 or 101 also gives strobes 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 32 | Effective byte address of the access |
| size_code_i | input | 3 | Access code: size and load signedness |
| is_store_i | input | 1 | 1 for a store, 0 for a load |
| store_data_i | input | 32 | Register value to be stored |
| mem_rdata_i | input | 32 | Word returned by the data memory |
| mem_addr_o | output | 32 | Word-aligned memory address |
| wr_strobe_o | output | 4 | Per-lane write enables, bit i for bits 8i+7:8i |
| wr_data_o | output | 32 | Store value replicated into lanes |
| load_data_o | output | 32 | Extracted and extended load result |
| misalign_o | output | 1 | Address does not suit the access size |

## Verification
Stores are tried at all four byte offsets, at both halfword offsets and at the aligned word address. The bench checks that each pattern lights exactly the strobes that match its offset. The memory word used for loads has distinct values in every lane, with the top bit set in some lanes and clear in others. This separates picking the wrong lane from getting the extension wrong, and sign fill from zero fill. Misaligned halfword and word addresses, unsupported codes, and loads fed with a nonzero store value then show that nothing is written and nothing leaks into the result.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  localparam logic [2:0] CODE_BYTE  = 3'b000;
  localparam logic [2:0] CODE_HALF  = 3'b001;
  localparam logic [2:0] CODE_WORD  = 3'b010;
  localparam logic [2:0] CODE_UBYTE = 3'b100;
  localparam logic [2:0] CODE_UHALF = 3'b101;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  typedef struct packed {
    acc_size_e size;
    logic      zero_ext;
    logic      misalign;
  } acc_ctrl_t;

endpackage

// File: rtl/lane_ctrl_decode.sv
module lane_ctrl_decode
  import lsu_lane_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [2:0]       code_i,
  input  logic [OFF_W-1:0] offset_i,
  output acc_ctrl_t        ctrl_o
);

  acc_ctrl_t c;

  always_comb begin
    c = '{size: SZ_NONE, zero_ext: 1'b0, misalign: 1'b0};
    unique case (code_i)
      CODE_BYTE:  c.size = SZ_BYTE;
      CODE_UBYTE: begin c.size = SZ_BYTE; c.zero_ext = 1'b1; end
      CODE_HALF:  c.size = SZ_HALF;
      CODE_UHALF: begin c.size = SZ_HALF; c.zero_ext = 1'b1; end
      CODE_WORD:  c.size = SZ_WORD;
      default:    c.size = SZ_NONE;
    endcase
    case (c.size)
      SZ_HALF: c.misalign = offset_i[0];
      SZ_WORD: c.misalign = (offset_i != '0);
      default: c.misalign = 1'b0;
    endcase
  end

  assign ctrl_o = c;

endmodule

// File: rtl/store_lane_gen.sv
module store_lane_gen
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input  acc_ctrl_t         ctrl_i,
  input  logic [2:0]        code_i,
  input  logic              is_store_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NBYTES-1:0] strobe_o,
  output logic [DATA_W-1:0] data_o
);

  // Only the three signed codes name a store width.
  logic store_ok;
  assign store_ok = is_store_i && !ctrl_i.misalign && !code_i[2]
                    && (ctrl_i.size != SZ_NONE);

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE = OFF_W'(i);
    logic hit;
    always_comb begin
      case (ctrl_i.size)
        SZ_BYTE: hit = (offset_i == LANE);
        SZ_HALF: hit = (offset_i[OFF_W-1:1] == LANE[OFF_W-1:1]);
        SZ_WORD: hit = 1'b1;
        default: hit = 1'b0;
      endcase
    end
    assign strobe_o[i] = store_ok && hit;
  end

  always_comb begin
    case (ctrl_i.size)
      SZ_BYTE: data_o = {NBYTES{data_i[7:0]}};
      SZ_HALF: data_o = {(NBYTES/2){data_i[15:0]}};
      SZ_WORD: data_o = data_i;
      default: data_o = '0;
    endcase
  end

endmodule

// File: rtl/load_lane_ext.sv
module load_lane_ext
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input  acc_ctrl_t         ctrl_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);

  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  logic [OFF_W-2:0] half_idx;

  assign half_idx = offset_i[OFF_W-1:1];
  assign byte_sel = rdata_i[{offset_i, 3'b000} +: 8];
  assign half_sel = rdata_i[{half_idx, 4'b0000} +: 16];

  always_comb begin
    data_o = '0;
    if (!ctrl_i.misalign) begin
      case (ctrl_i.size)
        SZ_BYTE: data_o = {{(DATA_W-8){byte_sel[7] & !ctrl_i.zero_ext}}, byte_sel};
        SZ_HALF: data_o = {{(DATA_W-16){half_sel[15] & !ctrl_i.zero_ext}}, half_sel};
        SZ_WORD: data_o = ctrl_i.zero_ext ? '0 : rdata_i;
        default: data_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/mem_lane_align.sv
module mem_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_code_i,
  input  logic              is_store_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [NBYTES-1:0] wr_strobe_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              misalign_o
);

  logic [OFF_W-1:0] offset;
  acc_ctrl_t        ctrl;

  assign offset     = addr_i[OFF_W-1:0];
  assign mem_addr_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign misalign_o = ctrl.misalign;

  lane_ctrl_decode #(.OFF_W(OFF_W)) u_dec (
    .code_i   (size_code_i),
    .offset_i (offset),
    .ctrl_o   (ctrl)
  );

  store_lane_gen #(.DATA_W(DATA_W)) u_st (
    .ctrl_i     (ctrl),
    .code_i     (size_code_i),
    .is_store_i (is_store_i),
    .offset_i   (offset),
    .data_i     (store_data_i),
    .strobe_o   (wr_strobe_o),
    .data_o     (wr_data_o)
  );

  load_lane_ext #(.DATA_W(DATA_W)) u_ld (
    .ctrl_i   (ctrl),
    .offset_i (offset),
    .rdata_i  (mem_rdata_i),
    .data_o   (load_data_o)
  );

  always_comb begin
    p_addr_aligned_r1: assert (mem_addr_o[OFF_W-1:0] == '0)
      else $error("memory address not word aligned");
    p_byte_onehot_r2: assert (!(is_store_i && size_code_i == CODE_BYTE)
                              || $onehot(wr_strobe_o))
      else $error("byte store strobe not one-hot");
    p_misalign_quiet_r6: assert (!misalign_o
                                 || (wr_strobe_o == '0 && load_data_o == '0))
      else $error("misaligned access leaked strobe or data");
    p_load_no_write_r7: assert (is_store_i || wr_strobe_o == '0)
      else $error("load raised a write strobe");
    p_odd_half_flag_r5: assert (!(size_code_i == CODE_HALF && addr_i[0])
                                || misalign_o)
      else $error("odd halfword address not flagged");
  end

endmodule

// File: tb/tb_mem_lane_align.sv
module tb_mem_lane_align;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] addr;
  logic [2:0]  code;
  logic        st;
  logic [31:0] sdata, rdata;
  logic [31:0] mem_addr, wdata, ldata;
  logic [3:0]  strobe;
  logic        mis;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_lane_align dut (
    .addr_i(addr), .size_code_i(code), .is_store_i(st),
    .store_data_i(sdata), .mem_rdata_i(rdata),
    .mem_addr_o(mem_addr), .wr_strobe_o(strobe), .wr_data_o(wdata),
    .load_data_o(ldata), .misalign_o(mis)
  );

  localparam logic [31:0] RWORD = 32'h7A_C3_15_9E;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [2:0] c, input logic s,
                       input logic [31:0] sd, input logic [31:0] rd);
    @(negedge clk);
    addr = a; code = c; st = s; sdata = sd; rdata = rd;
    #1;
  endtask

  task automatic t_reset_state;
    drive(32'h0, 3'b000, 1'b0, 32'h0, 32'h0);
    chk("R7 idle strobe", {28'h0, strobe}, 32'h0);
    chk("R5 idle flag", {31'h0, mis}, 32'h0);
    chk("R1 idle addr", mem_addr, 32'h0);
  endtask

  task automatic t_store_bytes;
    for (int i = 0; i < 4; i++) begin
      drive(32'h1000_0040 + i, 3'b000, 1'b1, 32'hDEAD_BEA5, RWORD);
      chk("R2 byte strobe", {28'h0, strobe}, 32'(4'b0001 << i));
      chk("R2 byte data", wdata, 32'hA5A5_A5A5);
      chk("R1 byte addr", mem_addr, 32'h1000_0040);
      chk("R5 byte flag", {31'h0, mis}, 32'h0);
    end
  endtask

  task automatic t_store_halves;
    drive(32'h0000_2002, 3'b001, 1'b1, 32'h1234_BEEF, RWORD);
    chk("R3 upper half strobe", {28'h0, strobe}, 32'hC);
    chk("R3 half data", wdata, 32'hBEEF_BEEF);
    drive(32'h0000_2000, 3'b001, 1'b1, 32'h1234_BEEF, RWORD);
    chk("R3 lower half strobe", {28'h0, strobe}, 32'h3);
  endtask

  task automatic t_store_word;
    drive(32'hFFFF_FFFC, 3'b010, 1'b1, 32'hCAFE_F00D, RWORD);
    chk("R4 word strobe", {28'h0, strobe}, 32'hF);
    chk("R4 word data", wdata, 32'hCAFE_F00D);
    chk("R1 word addr", mem_addr, 32'hFFFF_FFFC);
  endtask

  task automatic t_misaligned;
    drive(32'h0000_0101, 3'b001, 1'b1, 32'h1111_2222, RWORD);
    chk("R5 odd half flag", {31'h0, mis}, 32'h1);
    chk("R6 odd half strobe", {28'h0, strobe}, 32'h0);
    for (int i = 1; i < 4; i++) begin
      drive(32'h0000_0100 + i, 3'b010, 1'b1, 32'h1111_2222, RWORD);
      chk("R5 word flag", {31'h0, mis}, 32'h1);
      chk("R6 word strobe", {28'h0, strobe}, 32'h0);
      drive(32'h0000_0100 + i, 3'b010, 1'b0, 32'h0, RWORD);
      chk("R6 word load zero", ldata, 32'h0);
    end
    drive(32'h0000_0103, 3'b101, 1'b0, 32'h0, RWORD);
    chk("R5 uhalf flag", {31'h0, mis}, 32'h1);
    chk("R6 uhalf load zero", ldata, 32'h0);
    drive(32'h0000_0102, 3'b010, 1'b0, 32'h0, RWORD);
    chk("R1 misaligned addr", mem_addr, 32'h0000_0100);
  endtask

  task automatic t_load_bytes;
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      b = RWORD[8*i +: 8];
      drive(32'h0000_0300 + i, 3'b000, 1'b0, 32'hFFFF_FFFF, RWORD);
      chk("R8 signed byte", ldata, {{24{b[7]}}, b});
      chk("R7 load strobe", {28'h0, strobe}, 32'h0);
      drive(32'h0000_0300 + i, 3'b100, 1'b0, 32'hFFFF_FFFF, RWORD);
      chk("R9 unsigned byte", ldata, {24'h0, b});
    end
  endtask

  task automatic t_load_halves_words;
    drive(32'h0000_0400, 3'b001, 1'b0, 32'h0, RWORD);
    chk("R10 signed low half", ldata, 32'h0000_159E);
    drive(32'h0000_0402, 3'b001, 1'b0, 32'h0, 32'h8001_0000);
    chk("R10 signed high half", ldata, 32'hFFFF_8001);
    drive(32'h0000_0402, 3'b101, 1'b0, 32'h0, 32'h8001_0000);
    chk("R10 unsigned high half", ldata, 32'h0000_8001);
    drive(32'h0000_0400, 3'b101, 1'b0, 32'h0, 32'h0000_F00F);
    chk("R10 unsigned low half", ldata, 32'h0000_F00F);
    drive(32'h0000_0400, 3'b010, 1'b0, 32'h0, RWORD);
    chk("R11 word load", ldata, RWORD);
  endtask

  task automatic t_unsupported;
    logic [2:0] bad [3] = '{3'b011, 3'b110, 3'b111};
    for (int i = 0; i < 3; i++) begin
      drive(32'h0000_0501, bad[i], 1'b1, 32'h5555_AAAA, RWORD);
      chk("R12 bad strobe", {28'h0, strobe}, 32'h0);
      chk("R12 bad flag", {31'h0, mis}, 32'h0);
      chk("R12 bad load", ldata, 32'h0);
    end
    drive(32'h0000_0500, 3'b100, 1'b1, 32'h5555_AAAA, RWORD);
    chk("R12 unsigned-byte store", {28'h0, strobe}, 32'h0);
    drive(32'h0000_0502, 3'b101, 1'b1, 32'h5555_AAAA, RWORD);
    chk("R12 unsigned-half store", {28'h0, strobe}, 32'h0);
    drive(32'h0000_0500, 3'b010, 1'b0, 32'hFFFF_FFFF, RWORD);
    chk("R7 word load strobe", {28'h0, strobe}, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    addr = '0; code = '0; st = 1'b0; sdata = '0; rdata = '0;
    t_reset_state();
    t_store_bytes();
    t_store_halves();
    t_store_word();
    t_misaligned();
    t_load_bytes();
    t_load_halves_words();
    t_unsupported();
    finish_run();
  end

endmodule